// File: doc/BRIEF.md
# SDRAM Bank Command Sequencer

This block sits on the controller side of an SDRAM interface and turns a stream of host access requests into the command sequence the memory expects. Each request names a bank, a row, a column, a direction and an auto-precharge choice. The sequencer keeps a record of which row each bank holds open. It then issues what the bank needs: an activate for a closed bank, a precharge followed by an activate for a bank open on the wrong row, or nothing extra on a row hit. After that it issues the column read or write once the activate-to-column delay has passed.

The block has one pending column slot and one request input. While the held request waits out its activate-to-column delay, the request at the input may already activate a different bank, provided the activate-to-activate spacing is met. This lets accesses to two banks overlap; for example, a write to one bank can start while a read burst from another is still on the data bus. Column commands take priority over activates and precharges. Only one command leaves the block per clock, and columns go out in request order.

Host back-pressure: a request is offered with `req_valid` and must stay unchanged until `req_ready` is high in the same cycle. `req_ready` rises only when the request's row is open and the column slot is free. Activates and precharges made on the request's behalf do not consume it. All timing values are parameters, and every timer starts in the satisfied state after reset.

Top module: `sdram_cmd_seq`

## Requirements
- R1: A read or write command goes only to a bank that is open, and that bank's open row equals the row of the request the command serves; an activate goes only to a closed bank.
- R2: A column command to a bank comes at least T_RCD clocks after the activate of that bank.
- R3: Two activate commands are separated by at least T_RRD clocks.
- R4: While a request waits for T_RCD, the next request may activate another bank; column commands appear in the order requests were accepted, and with T_RCD=3, T_RRD=2 two back-to-back requests to idle banks give column commands two clocks apart.
- R5: Address bit AP_BIT of a column command carries the request's auto-precharge flag; a column with the flag set closes the bank, so the bank's next access starts with a fresh activate.
- R6: An activate to a bank comes at least T_RP clocks after that bank was closed by a precharge or an auto-precharge column.
- R7: A request whose bank is open on another row causes a precharge command (RAS_n and WE_n low, CAS_n high) with address bit AP_BIT low, before the activate.
- R8: Command encoding on {RAS_n, CAS_n, WE_n}: activate 011, read 101, write 100, precharge 010, no-operation 111. Chip select is low after reset, and during reset chip select and all three strobes are high.
- R9: `req_ready` is high only while `req_valid` is high, and every accepted request is served by exactly one column command; at most one command is issued per clock.
- R10: An activate drives the row on the address pins and the bank on the bank pins; a column command drives the column on address bits COL_W-1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken into the column slot this cycle |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row after the column command |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Row or column address; bit AP_BIT is the auto-precharge flag |

## Verification
The bench builds the block with four banks, T_RCD=3, T_RRD=2 and T_RP=3. Because T_RRD is shorter than T_RCD, a second activate fits inside the first bank's wait, so the interleaved order (activate, activate, read, write) and its exact clock spacing can be observed. A precharge recovery longer than one clock makes the gating of re-activation after an auto-precharge visible. A model that watches the pins checks every command against bank state and the three spacings while a mixed sequence of hits, misses, auto-precharge closes and extreme row and column values runs.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE
  } cmd_e;

  // Returns {ras_n, cas_n, we_n}
  function automatic logic [2:0] cmd_lines(cmd_e c);
    case (c)
      CMD_ACT: return 3'b011;
      CMD_RD:  return 3'b101;
      CMD_WR:  return 3'b100;
      CMD_PRE: return 3'b010;
      default: return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/seq_timer.sv
// Countdown that reports "done" once DELAY cycles have passed since load.
module seq_timer #(
  parameter int DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic done_o
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= CW'(DELAY - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/seq_bank.sv
// Open/closed state, open row and timing gates for one bank.
module seq_bank #(
  parameter int ROW_W = 12,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             close_i,
  input  logic             col_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rcd_ok_o,
  output logic             rp_ok_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      row_o  <= '0;
    end else if (act_i) begin
      open_o <= 1'b1;
      row_o  <= row_i;
    end else if (close_i) begin
      open_o <= 1'b0;
    end
  end

  seq_timer #(.DELAY(T_RCD)) u_rcd (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (act_i),
    .done_o (rcd_ok_o)
  );

  seq_timer #(.DELAY(T_RP)) u_rp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (close_i),
    .done_o (rp_ok_o)
  );

  p_act_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> !open_o);
  p_col_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    col_i |-> open_o);
  p_col_rcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col_i |-> rcd_ok_o);
  p_act_recover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> rp_ok_o);
  p_close_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    close_i |-> open_o);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RP      = 3,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  input  logic              req_autopre,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);

  // Pending column slot
  logic             p_valid;
  logic [BA_W-1:0]  p_bank;
  logic [COL_W-1:0] p_col;
  logic             p_write;
  logic             p_ap;

  logic [NUM_BANKS-1:0] bk_open, bk_rcd_ok, bk_rp_ok;
  logic [ROW_W-1:0]     bk_row [NUM_BANKS];
  logic                 rrd_ok;

  logic col_fire, act_fire, pre_fire, accept;
  logic req_hit, slot_same_bank;

  assign col_fire       = p_valid && bk_rcd_ok[p_bank];
  assign req_hit        = bk_open[req_bank] && (bk_row[req_bank] == req_row);
  assign slot_same_bank = p_valid && (p_bank == req_bank);

  // Column slot has priority; input side uses the bus only when it is free.
  always_comb begin
    act_fire = 1'b0;
    pre_fire = 1'b0;
    accept   = 1'b0;
    if (req_valid && !col_fire) begin
      if (req_hit)                accept   = !p_valid;
      else if (bk_open[req_bank]) pre_fire = !slot_same_bank;
      else                        act_fire = bk_rp_ok[req_bank] && rrd_ok;
    end
  end

  assign req_ready = accept;

  seq_timer #(.DELAY(T_RRD)) u_rrd (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (act_fire),
    .done_o (rrd_ok)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel_in, sel_slot;
    assign sel_in   = (req_bank == BA_W'(b));
    assign sel_slot = (p_bank == BA_W'(b));

    seq_bank #(.ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (act_fire && sel_in),
      .close_i  ((pre_fire && sel_in) || (col_fire && p_ap && sel_slot)),
      .col_i    (col_fire && sel_slot),
      .row_i    (req_row),
      .open_o   (bk_open[b]),
      .row_o    (bk_row[b]),
      .rcd_ok_o (bk_rcd_ok[b]),
      .rp_ok_o  (bk_rp_ok[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_valid <= 1'b0;
      p_bank  <= '0;
      p_col   <= '0;
      p_write <= 1'b0;
      p_ap    <= 1'b0;
    end else if (accept) begin
      p_valid <= 1'b1;
      p_bank  <= req_bank;
      p_col   <= req_col;
      p_write <= req_write;
      p_ap    <= req_autopre;
    end else if (col_fire) begin
      p_valid <= 1'b0;
    end
  end

  // Next command on the pins
  cmd_e              nxt_cmd;
  logic [BA_W-1:0]   nxt_ba;
  logic [ADDR_W-1:0] nxt_addr;

  always_comb begin
    nxt_cmd  = CMD_NOP;
    nxt_ba   = req_bank;
    nxt_addr = '0;
    if (col_fire) begin
      nxt_cmd                = p_write ? CMD_WR : CMD_RD;
      nxt_ba                 = p_bank;
      nxt_addr[COL_W-1:0]    = p_col;
      nxt_addr[AP_BIT]       = p_ap;
    end else if (act_fire) begin
      nxt_cmd  = CMD_ACT;
      nxt_addr = ADDR_W'(req_row);
    end else if (pre_fire) begin
      nxt_cmd  = CMD_PRE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_cs_n                      <= 1'b1;
      {sd_ras_n, sd_cas_n, sd_we_n} <= 3'b111;
      sd_ba                        <= '0;
      sd_addr                      <= '0;
    end else begin
      sd_cs_n                      <= 1'b0;
      {sd_ras_n, sd_cas_n, sd_we_n} <= cmd_lines(nxt_cmd);
      sd_ba                        <= nxt_ba;
      sd_addr                      <= nxt_addr;
    end
  end

  // Cycles since the last activate, saturating, for the spacing check.
  localparam int SW = $clog2(T_RRD + 1);
  logic [SW-1:0] since_act;
  always_ff @(posedge clk) begin
    if (!rst_n)                          since_act <= SW'(T_RRD);
    else if (act_fire)                   since_act <= SW'(1);
    else if (since_act != SW'(T_RRD))    since_act <= since_act + 1'b1;
  end

  p_act_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> (since_act >= SW'(T_RRD)));
  p_one_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_fire, pre_fire, col_fire, accept}));
  p_ready_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (req_valid && bk_open[req_bank]));
  p_slot_served_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (p_valid && !col_fire) |=> p_valid);

endmodule

// File: tb/sdram_cmd_seq_tb_top.sv
module sdram_cmd_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 3;
  localparam int T_RRD = 2;
  localparam int T_RP  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [11:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic        req_write = 1'b0;
  logic        req_autopre = 1'b0;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_seq #(
    .NUM_BANKS(4), .ROW_W(12), .COL_W(8), .ADDR_W(12), .AP_BIT(10),
    .T_RCD(T_RCD), .T_RRD(T_RRD), .T_RP(T_RP)
  ) dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_bank, .req_row, .req_col,
    .req_write, .req_autopre, .sd_cs_n, .sd_ras_n, .sd_cas_n, .sd_we_n,
    .sd_ba, .sd_addr
  );

  // Request vector: {bank[2], row[12], col[8], write, autopre}
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 12'd5,     8'h10, 1'b0, 1'b0},  // hit on open row
    {2'd1, 12'd7,     8'h20, 1'b1, 1'b0},  // bank closed earlier by auto-precharge
    {2'd0, 12'd9,     8'h30, 1'b0, 1'b0},  // row miss -> precharge
    {2'd2, 12'd1,     8'h40, 1'b1, 1'b1},  // write with auto-precharge
    {2'd2, 12'd1,     8'h41, 1'b0, 1'b0},  // same row, must re-activate
    {2'd3, 12'hFFF,   8'hFF, 1'b1, 1'b1},  // extreme row/column
    {2'd1, 12'd7,     8'h21, 1'b0, 1'b1},  // hit, then close
    {2'd0, 12'd9,     8'h00, 1'b1, 1'b0},  // hit
    {2'd3, 12'd0,     8'h00, 1'b0, 1'b0},  // re-activate after close
    {2'd0, 12'd0,     8'h80, 1'b0, 1'b1}   // miss + auto-precharge
  };

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  bit          m_open [4];
  logic [11:0] m_row [4];
  int          m_act [4];
  int          m_pre [4];
  int          m_last_act = -1000;
  int          st_act [4];
  int          st_col [4];
  int          act_cnt [4];
  int          pre_cnt = 0;
  logic [23:0] exp_q [$];

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int actual, input int expected);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, actual, expected);
    end
  endtask

  // Pin monitor with bank-state reference model
  always @(negedge clk) begin
    if (rst_n && !sd_cs_n) begin
      case ({sd_ras_n, sd_cas_n, sd_we_n})
        3'b011: begin
          chk(!m_open[sd_ba], "R1", "activate to open bank", m_open[sd_ba], 0);
          chk(cyc - m_last_act >= T_RRD, "R3", "activate spacing", cyc - m_last_act, T_RRD);
          chk(cyc - m_pre[sd_ba] >= T_RP, "R6", "precharge recovery", cyc - m_pre[sd_ba], T_RP);
          m_open[sd_ba] = 1'b1;
          m_row[sd_ba]  = sd_addr;
          m_act[sd_ba]  = cyc;
          m_last_act    = cyc;
          st_act[sd_ba] = cyc;
          act_cnt[sd_ba]++;
        end
        3'b101, 3'b100: begin
          logic [23:0] e;
          chk(m_open[sd_ba], "R1", "column to closed bank", m_open[sd_ba], 1);
          chk(cyc - m_act[sd_ba] >= T_RCD, "R2", "activate-to-column", cyc - m_act[sd_ba], T_RCD);
          chk(exp_q.size() > 0, "R9", "column without request", exp_q.size(), 1);
          if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(sd_ba == e[23:22], "R4", "column order bank", sd_ba, e[23:22]);
            chk(m_row[sd_ba] == e[21:10], "R1", "open row", m_row[sd_ba], e[21:10]);
            chk(sd_addr[7:0] == e[9:2], "R10", "column address", sd_addr[7:0], e[9:2]);
            chk(!sd_we_n == e[1], "R8", "read/write encoding", !sd_we_n, e[1]);
            chk(sd_addr[10] == e[0], "R5", "auto-precharge bit", sd_addr[10], e[0]);
          end
          if (sd_addr[10]) begin
            m_open[sd_ba] = 1'b0;
            m_pre[sd_ba]  = cyc;
          end
          st_col[sd_ba] = cyc;
        end
        3'b010: begin
          chk(m_open[sd_ba], "R7", "precharge of closed bank", m_open[sd_ba], 1);
          chk(sd_addr[10] == 1'b0, "R7", "precharge AP bit", sd_addr[10], 0);
          m_open[sd_ba] = 1'b0;
          m_pre[sd_ba]  = cyc;
          pre_cnt++;
        end
        3'b111: ;
        default: chk(1'b0, "R8", "illegal encoding",
                     {sd_ras_n, sd_cas_n, sd_we_n}, 7);
      endcase
    end
  end

  task automatic send(input logic [23:0] v);
    @(negedge clk);
    req_bank    = v[23:22];
    req_row     = v[21:10];
    req_col     = v[9:2];
    req_write   = v[1];
    req_autopre = v[0];
    req_valid   = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(v);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) begin
      m_open[b] = 1'b0; m_row[b] = '0; m_act[b] = -1000; m_pre[b] = -1000;
      st_act[b] = 0; st_col[b] = 0; act_cnt[b] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state of the pins
    chk(sd_cs_n == 1'b1, "R8", "reset cs_n", sd_cs_n, 1);
    chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R8", "reset strobes",
        {sd_ras_n, sd_cas_n, sd_we_n}, 7);
    chk(req_ready == 1'b0, "R9", "ready without valid", req_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sd_cs_n == 1'b0 && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R8",
        "idle NOP", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 7);

    // R4: interleave of a read on bank 0 and a write on bank 1
    send({2'd0, 12'd5, 8'h11, 1'b0, 1'b0});
    send({2'd1, 12'd7, 8'h22, 1'b1, 1'b1});
    repeat (8) @(negedge clk);
    chk(st_act[1] - st_act[0] == T_RRD, "R3", "second activate gap",
        st_act[1] - st_act[0], T_RRD);
    chk(st_act[1] < st_col[0], "R4", "activate before earlier read",
        st_act[1] - st_col[0], -1);
    chk(st_col[0] - st_act[0] == T_RCD, "R2", "read delay", st_col[0] - st_act[0], T_RCD);
    chk(st_col[1] - st_col[0] == 2, "R4", "read-to-write gap", st_col[1] - st_col[0], 2);

    // Table of mixed requests
    for (int i = 0; i < NV; i++) send(VEC[i]);
    repeat (20) @(negedge clk);

    chk(act_cnt[2] == 2, "R5", "bank 2 re-activated after auto-precharge", act_cnt[2], 2);
    chk(pre_cnt == 2, "R7", "precharges for row misses", pre_cnt, 2);
    chk(exp_q.size() == 0, "R9", "requests left unserved", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule